// File: doc/BRIEF.md
# Three-Channel Glitch-Free PWM Generator

This block produces three pulse width modulated outputs from two shared time bases. Each time base is a 10-bit count: an 8-bit coarse counter forms the upper bits, and a 2-bit sub-count that advances on every clock forms the lowest two bits. Each time base has its own 8-bit period register. When the coarse bits equal the period register and the sub-count is at its last value, the time base is at its final count. On the next clock it returns to zero. A period therefore lasts (P+1)*4 clocks, where P is the period register value.

Channel 1 always runs from time base 1. Channels 2 and 3 each have a select input that picks time base 1 or time base 2. Every channel has two duty registers. The master register is the one that is written. The slave register feeds the comparator and takes the master value only at a period boundary, so a duty write in the middle of a period can never drop or stretch a pulse. Each output is high from the start of the period until the count reaches the slave duty value.

Each channel also has an enable input that chooses what its pin carries. With the enable set, the pin is driven with the PWM signal. With the enable clear, the pin is a general port bit with its own data and direction. Register writes are single-cycle strobes that are always accepted, so there is no back-pressure. A one-cycle pulse per time base marks the last count of each period and can serve as an interrupt request.

Top module: `pwm3_dbuf`

## Requirements
- R1: After reset the pins are undriven (`pin_oe` = 0, `pin_out` = 0 when the port data and direction inputs are 0), both period registers hold 0xFF and both counts are 0. The first `period_hit` pulse therefore appears 1023 clocks after reset is released.
- R2: With period register value P, a time base counts 0 to 4P+3 and then wraps to 0. Consecutive `period_hit` pulses of the same time base are (P+1)*4 clocks apart.
- R3: With slave duty D, where 0 < D < (P+1)*4, the output is high for counts 0 to D-1 and low for the rest of the period, giving exactly D high clocks per period.
- R4: A slave duty of 0 keeps the output low for the entire period, and a boundary with a zero duty does not set it high.
- R5: A slave duty of (P+1)*4 or more keeps the output high for the entire period (100%).
- R6: A duty write updates only the master register. The slave register changes only on the clock that ends a period of the channel's time base. A value written mid-period takes effect in the next period, and the current period completes with the old duty.
- R7: `tb_sel[j]` selects the time base of channel j+2: 0 selects time base 1 and 1 selects time base 2. Channel 1 always uses time base 1.
- R8: With `ch_en[i]` = 1, `pin_oe[i]` = 1 and `pin_out[i]` carries the PWM signal, whatever `port_dir[i]` says. With `ch_en[i]` = 0, `pin_out[i]` = `port_out[i]` and `pin_oe[i]` = `port_dir[i]`.
- R9: `period_hit[k]` is high for exactly one clock, during the last count of the period of time base k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_we | input | 2 | Write strobe per time base period register |
| period_wdata | input | 8 | Period value to write |
| duty_we | input | 3 | Write strobe per channel master duty register |
| duty_wdata | input | 10 | Duty value to write |
| tb_sel | input | 2 | Time base select for channels 2 and 3 (1 = time base 2) |
| ch_en | input | 3 | Per-channel PWM pin enable |
| port_out | input | 3 | Port data used when the PWM enable is clear |
| port_dir | input | 3 | Port direction used when the PWM enable is clear (1 = drive) |
| pin_out | output | 3 | Pin data |
| pin_oe | output | 3 | Pin output enable |
| period_hit | output | 2 | One-clock end-of-period pulse per time base |

## Verification
The assertions check on every cycle the properties that hold at each clock: each hit pulse lasts one clock and is followed by a zero count, a slave duty register changes only right after its channel's boundary, each output level just after a boundary matches whether the new duty is zero, and each pin's drive follows its enable and direction. Pulse widths for given duty values, the 0% and 100% limits, the period length, the reset-to-first-hit time and the routing of channels to the selected time base are shown only by the bench's scenarios, which count high clocks over whole periods. The mid-period rewrite from duty 30 to duty 10 with a 52-clock period is a bench scenario. It shows that the current period keeps 30 high clocks and the next one has 10.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int unsigned DEF_TB_W   = 8;
  localparam int unsigned DEF_SUB_W  = 2;
  localparam int unsigned DEF_NUM_CH = 3;
  localparam int unsigned NUM_TB     = 2;

  typedef struct packed {
    logic drive;
    logic data;
  } pin_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned TB_W  = 8,
  parameter int unsigned SUB_W = 2,
  localparam int unsigned CNT_W = TB_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_we,
  input  logic [TB_W-1:0]  per_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [TB_W-1:0] per_q;

  // final count: coarse bits at period, sub-count saturated
  assign hit = (cnt[CNT_W-1:SUB_W] == per_q) && (&cnt[SUB_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '1;
      cnt   <= '0;
    end else begin
      if (per_we) per_q <= per_wdata;
      cnt <= hit ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             duty_we,
  input  logic [CNT_W-1:0] duty_wdata,
  input  logic [CNT_W-1:0] tb_cnt,
  input  logic             tb_hit,
  output logic             pwm,
  output logic [CNT_W-1:0] slave_q
);
  logic [CNT_W-1:0] master_q;
  logic [CNT_W-1:0] cnt_next;

  assign cnt_next = tb_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= '0;
      slave_q  <= '0;
      pwm      <= 1'b0;
    end else begin
      if (duty_we) master_q <= duty_wdata;
      if (tb_hit) begin
        slave_q <= master_q;
        pwm     <= |master_q;     // zero duty: reset wins over set
      end else if (cnt_next == slave_q) begin
        pwm <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_pin_mux.sv
module pwm_pin_mux (
  input  logic            en,
  input  logic            pwm,
  input  logic            port_data,
  input  logic            port_drive,
  output pwm3_pkg::pin_t  pin
);
  always_comb begin
    if (en) begin
      pin.drive = 1'b1;
      pin.data  = pwm;
    end else begin
      pin.drive = port_drive;
      pin.data  = port_data;
    end
  end
endmodule

// File: rtl/pwm3_dbuf.sv
module pwm3_dbuf #(
  parameter int unsigned TB_W   = pwm3_pkg::DEF_TB_W,
  parameter int unsigned SUB_W  = pwm3_pkg::DEF_SUB_W,
  parameter int unsigned NUM_CH = pwm3_pkg::DEF_NUM_CH,
  localparam int unsigned CNT_W  = TB_W + SUB_W,
  localparam int unsigned NUM_TB = pwm3_pkg::NUM_TB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_TB-1:0] period_we,
  input  logic [TB_W-1:0]   period_wdata,
  input  logic [NUM_CH-1:0] duty_we,
  input  logic [CNT_W-1:0]  duty_wdata,
  input  logic [NUM_CH-2:0] tb_sel,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] port_out,
  input  logic [NUM_CH-1:0] port_dir,
  output logic [NUM_CH-1:0] pin_out,
  output logic [NUM_CH-1:0] pin_oe,
  output logic [NUM_TB-1:0] period_hit
);
  logic [NUM_TB-1:0][CNT_W-1:0] tb_cnt;
  logic [NUM_TB-1:0]            tb_hit;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;
  logic [NUM_CH-1:0]            ch_hit;
  logic [NUM_CH-1:0][CNT_W-1:0] slave;
  logic [NUM_CH-1:0]            pwm;

  for (genvar k = 0; k < NUM_TB; k++) begin : g_tb
    pwm_timebase #(.TB_W(TB_W), .SUB_W(SUB_W)) tb_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .per_we    (period_we[k]),
      .per_wdata (period_wdata),
      .cnt       (tb_cnt[k]),
      .hit       (tb_hit[k])
    );
  end

  assign period_hit = tb_hit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm3_pkg::pin_t pin;

    if (i == 0) begin : g_fixed
      assign ch_cnt[i] = tb_cnt[0];
      assign ch_hit[i] = tb_hit[0];
    end else begin : g_sel
      assign ch_cnt[i] = tb_sel[i-1] ? tb_cnt[1] : tb_cnt[0];
      assign ch_hit[i] = tb_sel[i-1] ? tb_hit[1] : tb_hit[0];
    end

    pwm_channel #(.CNT_W(CNT_W)) ch_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .duty_we    (duty_we[i]),
      .duty_wdata (duty_wdata),
      .tb_cnt     (ch_cnt[i]),
      .tb_hit     (ch_hit[i]),
      .pwm        (pwm[i]),
      .slave_q    (slave[i])
    );

    pwm_pin_mux mux_i (
      .en         (ch_en[i]),
      .pwm        (pwm[i]),
      .port_data  (port_out[i]),
      .port_drive (port_dir[i]),
      .pin        (pin)
    );

    assign pin_out[i] = pin.data;
    assign pin_oe[i]  = pin.drive;
  end
endmodule

// File: rtl/pwm3_dbuf_chk.sv
module pwm3_dbuf_chk #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned NUM_TB = 2,
  parameter int unsigned CNT_W  = 10
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_TB-1:0][CNT_W-1:0] tb_cnt,
  input logic [NUM_TB-1:0]            tb_hit,
  input logic [NUM_CH-1:0]            ch_hit,
  input logic [NUM_CH-1:0][CNT_W-1:0] slave,
  input logic [NUM_CH-1:0]            pwm,
  input logic [NUM_CH-1:0]            ch_en,
  input logic [NUM_CH-1:0]            port_dir,
  input logic [NUM_CH-1:0]            pin_oe
);
  for (genvar k = 0; k < NUM_TB; k++) begin : g_tb_chk
    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tb_hit[k] |=> !tb_hit[k]); // R9
    AST_TB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      tb_hit[k] |=> (tb_cnt[k] == '0)); // R2
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch_chk
    AST_SLAVE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(slave[i]) |-> $past(ch_hit[i])); // R6
    AST_BOUNDARY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      ch_hit[i] |=> (pwm[i] == (slave[i] != '0))); // R4
    AST_PIN_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      ch_en[i] |-> pin_oe[i]); // R8
    AST_PIN_PORT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |-> (pin_oe[i] == port_dir[i])); // R8
  end
endmodule

bind pwm3_dbuf pwm3_dbuf_chk #(
  .NUM_CH (NUM_CH),
  .NUM_TB (NUM_TB),
  .CNT_W  (CNT_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .tb_cnt   (tb_cnt),
  .tb_hit   (tb_hit),
  .ch_hit   (ch_hit),
  .slave    (slave),
  .pwm      (pwm),
  .ch_en    (ch_en),
  .port_dir (port_dir),
  .pin_oe   (pin_oe)
);

// File: tb/pwm3_dbuf_tb_top.sv
`timescale 1ns/1ps
module pwm3_dbuf_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] period_we = '0;
  logic [7:0] period_wdata = '0;
  logic [2:0] duty_we = '0;
  logic [9:0] duty_wdata = '0;
  logic [1:0] tb_sel = '0;
  logic [2:0] ch_en = '0;
  logic [2:0] port_out = '0;
  logic [2:0] port_dir = '0;
  logic [2:0] pin_out;
  logic [2:0] pin_oe;
  logic [1:0] period_hit;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pwm3_dbuf dut_i (
    .clk(clk), .rst_n(rst_n), .period_we(period_we), .period_wdata(period_wdata),
    .duty_we(duty_we), .duty_wdata(duty_wdata), .tb_sel(tb_sel), .ch_en(ch_en),
    .port_out(port_out), .port_dir(port_dir), .pin_out(pin_out), .pin_oe(pin_oe),
    .period_hit(period_hit)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_period(int k, int v);
    @(negedge clk);
    period_we[k] = 1'b1; period_wdata = v[7:0];
    @(negedge clk);
    period_we = '0;
  endtask

  task automatic wr_duty(int ch, int v);
    @(negedge clk);
    duty_we[ch] = 1'b1; duty_wdata = v[9:0];
    @(negedge clk);
    duty_we = '0;
  endtask

  task automatic wait_hit(int k);
    do @(negedge clk); while (!period_hit[k]);
  endtask

  // high clocks of channel ch over the whole period following the next hit of tb k
  task automatic measure(int ch, int k, int len, output int highs);
    highs = 0;
    wait_hit(k);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pin_out[ch]) highs++;
    end
  endtask

  task automatic t_reset;
    int wait_cnt;
    check("R1 oe", pin_oe, 0);
    check("R1 out", pin_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cnt = 0;
    while (!period_hit[0]) begin
      @(negedge clk);
      wait_cnt++;
    end
    check("R1 first hit", wait_cnt, 1023);
    check("R1 both tb", period_hit, 3);
  endtask

  task automatic t_pins;
    port_dir = 3'b101; port_out = 3'b001;
    @(negedge clk);
    check("R8 port oe", pin_oe, 5);
    check("R8 port data", pin_out, 1);
    ch_en = 3'b111; port_dir = 3'b000;
    @(negedge clk);
    check("R8 forced oe", pin_oe, 7);
    port_out = 3'b000;
  endtask

  task automatic t_period;
    int gap;
    wr_period(0, 2);
    wait_hit(0);
    @(negedge clk);
    check("R9 pulse width", period_hit[0], 0);
    gap = 1;
    while (!period_hit[0]) begin
      @(negedge clk);
      gap++;
    end
    check("R2 period length", gap, 12);
  endtask

  task automatic t_duty;
    int h;
    wr_duty(0, 5);  measure(0, 0, 12, h); check("R3 duty 5", h, 5);
    wr_duty(0, 1);  measure(0, 0, 12, h); check("R3 duty 1", h, 1);
    wr_duty(0, 0);  measure(0, 0, 12, h); check("R4 duty 0", h, 0);
    wr_duty(0, 12); measure(0, 0, 12, h); check("R5 duty N", h, 12);
    wr_duty(0, 1023); measure(0, 0, 12, h); check("R5 duty max", h, 12);
  endtask

  task automatic t_glitch;
    int h;
    wr_period(0, 12);           // 52-clock period
    wr_duty(0, 30);
    measure(0, 0, 52, h);
    measure(0, 0, 52, h); check("R6 old duty", h, 30);
    wait_hit(0);
    h = 0;
    for (int i = 0; i < 52; i++) begin
      @(negedge clk);
      if (pin_out[0]) h++;
      if (i == 15) begin duty_we[0] = 1'b1; duty_wdata = 10'd10; end
      if (i == 16) duty_we = '0;
    end
    check("R6 mid-period write", h, 30);
    measure(0, 0, 52, h); check("R6 next period", h, 10);
  endtask

  task automatic t_select;
    int h;
    wr_period(0, 2);            // tb1: 12 clocks
    wr_period(1, 4);            // tb2: 20 clocks
    tb_sel = 2'b11;
    wr_duty(1, 7); wr_duty(2, 15);
    measure(1, 1, 20, h); check("R7 ch2 on tb2", h, 7);
    measure(2, 1, 20, h); check("R7 ch3 on tb2", h, 15);
    tb_sel = 2'b00;
    measure(2, 0, 12, h);
    measure(2, 0, 12, h); check("R7 ch3 on tb1", h, 12);
  endtask

  initial begin
    t_reset();
    t_pins();
    t_period();
    t_duty();
    t_glitch();
    t_select();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule